// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing heart of a two-channel pulse-width generator. It turns the system clock into a slower tick through two chained divider stages. On each tick it moves a 16-bit count up, down, or up then down against a single period value that both output channels share. It can also hold the count still. Compare and waveform logic placed downstream watch the count, the direction flag and two single-cycle event strobes. One strobe marks the count at zero, the other marks the count at the period.

Software reaches the block through a small write port. With `wr_sel` low, a write replaces the control word. With `wr_sel` high, it supplies a new period. The control word decides whether a new period goes straight into the active register or waits in a shadow copy. A period held in the shadow copy is adopted at the next zero event, so a running waveform never sees a period change part-way through a cycle.

The counter is a two-state machine. State `S_UP` means the count is rising and `S_DOWN` means it is falling. In up mode the state is pinned to `S_UP`, and in down mode it is pinned to `S_DOWN`. In up-down mode, `S_UP` moves to `S_DOWN` on a tick that finds the count at or above the period, and `S_DOWN` moves to `S_UP` on a tick that finds the count at zero. In hold mode the state keeps its last value.

Top module: `pwm_timebase`

## Requirements
- R1: After reset, `count` is 0, `dir_up` is 1 and `active_period` is 0. The control word is all zeros, which selects up mode, shadow loading and division by 1.
- R2: Mode code 00 (control bits [1:0]) counts up by one per tick. A tick that finds the count at or above the effective period sets the count to 0.
- R3: Mode code 01 counts down by one per tick. A tick that finds the count at 0 sets it to the effective period. `dir_up` is 0 in this mode.
- R4: Mode code 10 counts up to the period and then down to 0, over and over. `dir_up` is 1 while rising and 0 while falling.
- R5: Mode code 11 holds `count` unchanged, and `zero_evt` and `period_evt` stay low.
- R6: Control bits [12:10] hold a code n, and bits [9:7] hold a code m. The count moves once every 2^n × (m = 0 ? 1 : 2·m) clocks.
- R7: `zero_evt` is high only in a tick cycle where the count is 0. `period_evt` is high only in a tick cycle where the count equals `active_period`. When the division is above 1, each strobe lasts exactly one clock per occurrence.
- R8: With control bit 3 at 0, a period write goes only to the shadow copy. `active_period` takes the shadow value at the clock edge that ends a `zero_evt` cycle, and that same edge already counts against the new value.
- R9: With control bit 3 at 1, a period write updates both the active period and the shadow copy at the clock edge of the write.
- R10: A write with `wr_en` high takes effect at the next rising clock edge. `wr_sel` = 0 selects the control word and `wr_sel` = 1 selects the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 period |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current time-base count |
| dir_up | output | 1 | 1 while counting upward |
| zero_evt | output | 1 | Tick-qualified strobe, count at zero |
| period_evt | output | 1 | Tick-qualified strobe, count at period |
| active_period | output | 16 | Period currently in force |

## Verification
The hardest case to reach from the ports is a shadowed period change in flight. The new value has to sit in the shadow copy while the count passes through the old period, and then be adopted exactly at the zero event. The bench writes a shorter period in shadow mode while the counter is part-way through a longer one. It then checks, cycle by cycle, that `active_period` keeps the old value up to and including the zero cycle, and that the very next period already ends at the new value. Up-down reversal at zero is reached by running more than one full triangle, so that the second visit to zero arrives from `S_DOWN` with `dir_up` low.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

    localparam int POW_W    = 3;
    localparam int EVN_W    = 3;
    localparam int MODE_LSB = 0;
    localparam int LOAD_BIT = 3;
    localparam int EVN_LSB  = 7;
    localparam int POW_LSB  = 10;

    typedef enum logic [1:0] {
        MODE_UP   = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UPDN = 2'b10,
        MODE_HOLD = 2'b11
    } cnt_mode_e;

    typedef enum logic {
        S_UP   = 1'b0,
        S_DOWN = 1'b1
    } dir_state_e;

    typedef struct packed {
        logic [POW_W-1:0] pow_code;
        logic [EVN_W-1:0] even_code;
        logic             load_now;
        cnt_mode_e        mode;
    } tb_ctrl_t;

    function automatic tb_ctrl_t decode_ctrl(input logic [15:0] w);
        tb_ctrl_t c;
        c.mode      = cnt_mode_e'(w[MODE_LSB +: 2]);
        c.load_now  = w[LOAD_BIT];
        c.even_code = w[EVN_LSB +: EVN_W];
        c.pow_code  = w[POW_LSB +: POW_W];
        return c;
    endfunction

endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler
    import pwm_tb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POW_W-1:0] pow_code,
    input  logic [EVN_W-1:0] even_code,
    output logic             tick
);
    localparam int P1_W = (1 << POW_W) - 1;
    localparam int S2_W = EVN_W + 1;

    logic [P1_W-1:0] p1_q;
    logic [S2_W-1:0] s2_q;
    logic [P1_W-1:0] lim1;
    logic [S2_W-1:0] lim2;
    logic            p1_wrap;
    logic            s2_wrap;

    always_comb begin
        lim1    = P1_W'((32'd1 << pow_code) - 32'd1);
        lim2    = (even_code == '0) ? '0 : ({even_code, 1'b0} - S2_W'(1));
        p1_wrap = (p1_q >= lim1);
        s2_wrap = (s2_q >= lim2);
        tick    = p1_wrap && s2_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1_q <= '0;
            s2_q <= '0;
        end else begin
            p1_q <= p1_wrap ? '0 : p1_q + P1_W'(1);
            if (p1_wrap) begin
                s2_q <= s2_wrap ? '0 : s2_q + S2_W'(1);
            end
        end
    end
endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_prd,
    input  logic             wr_now,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load_evt,
    output logic [CNT_W-1:0] prd_act,
    output logic [CNT_W-1:0] prd_eff
);
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_prd) begin
                shadow_q <= wr_data;
            end
            if (wr_prd && wr_now) begin
                active_q <= wr_data;
            end else if (load_evt) begin
                active_q <= shadow_q;
            end
        end
    end

    assign prd_act = active_q;
    assign prd_eff = load_evt ? shadow_q : active_q;
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] prd_eff,
    input  logic [CNT_W-1:0] prd_act,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             zero_evt,
    output logic             period_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    dir_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_UP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (mode)
            MODE_UP: begin
                st_d = S_UP;
                if (tick) cnt_d = (cnt_q >= prd_eff) ? '0 : cnt_q + ONE;
            end
            MODE_DOWN: begin
                st_d = S_DOWN;
                if (tick) cnt_d = (cnt_q == '0) ? prd_eff : cnt_q - ONE;
            end
            MODE_UPDN: begin
                if (tick) begin
                    unique case (st_q)
                        S_UP: begin
                            if (cnt_q >= prd_eff) begin
                                st_d  = S_DOWN;
                                cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
                            end else begin
                                cnt_d = cnt_q + ONE;
                            end
                        end
                        S_DOWN: begin
                            if (cnt_q == '0) begin
                                st_d  = S_UP;
                                cnt_d = (prd_eff == '0) ? '0 : ONE;
                            end else begin
                                cnt_d = cnt_q - ONE;
                            end
                        end
                    endcase
                end
            end
            MODE_HOLD: begin
                st_d  = st_q;
                cnt_d = cnt_q;
            end
        endcase
    end

    always_comb begin
        count      = cnt_q;
        zero_evt   = tick && (mode != MODE_HOLD) && (cnt_q == '0);
        period_evt = tick && (mode != MODE_HOLD) && (cnt_q == prd_act);
        unique case (mode)
            MODE_UP:   dir_up = 1'b1;
            MODE_DOWN: dir_up = 1'b0;
            MODE_UPDN: dir_up = (st_q == S_UP);
            MODE_HOLD: dir_up = (st_q == S_UP);
        endcase
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             zero_evt,
    output logic             period_evt,
    output logic [CNT_W-1:0] active_period
);
    tb_ctrl_t         ctrl_q;
    logic             tick;
    logic             wr_prd;
    logic             imm_wr;
    logic [CNT_W-1:0] prd_eff;

    assign wr_prd = wr_en && wr_sel;
    assign imm_wr = wr_prd && ctrl_q.load_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && !wr_sel) begin
            ctrl_q <= decode_ctrl(wr_data[15:0]);
        end
    end

    pwm_tb_prescaler u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .pow_code  (ctrl_q.pow_code),
        .even_code (ctrl_q.even_code),
        .tick      (tick)
    );

    pwm_tb_period #(.CNT_W(CNT_W)) u_prd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_prd   (wr_prd),
        .wr_now   (ctrl_q.load_now),
        .wr_data  (wr_data),
        .load_evt (zero_evt),
        .prd_act  (active_period),
        .prd_eff  (prd_eff)
    );

    pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .mode       (ctrl_q.mode),
        .prd_eff    (prd_eff),
        .prd_act    (active_period),
        .count      (count),
        .dir_up     (dir_up),
        .zero_evt   (zero_evt),
        .period_evt (period_evt)
    );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             tick,
    input logic             imm_wr,
    input logic [CNT_W-1:0] count,
    input logic             zero_evt,
    input logic             period_evt,
    input logic [CNT_W-1:0] active_period
);
    a_r5_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(count));

    a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |-> (!zero_evt && !period_evt));

    a_r7_evt_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt || period_evt) |-> tick);

    a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_UP) && tick && (count != '0) && (count < active_period))
        |=> (count == $past(count) + CNT_W'(1)));

    a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_DOWN) && tick && (count != '0))
        |=> (count == $past(count) - CNT_W'(1)));

    a_r8_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_wr && !zero_evt) |=> $stable(active_period));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (ctrl_q.mode),
    .tick          (tick),
    .imm_wr        (imm_wr),
    .count         (count),
    .zero_evt      (zero_evt),
    .period_evt    (period_evt),
    .active_period (active_period)
);

// File: tb/pwm_timebase_bench.sv
`timescale 1ns/1ps
module pwm_timebase_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        dir_up, zero_evt, period_evt;
    logic [15:0] active_period;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    pwm_timebase u_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .count(count), .dir_up(dir_up),
        .zero_evt(zero_evt), .period_evt(period_evt),
        .active_period(active_period)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk(count == 0, "R1 count", count, 0);
        chk(dir_up == 1, "R1 dir_up", dir_up, 1);
        chk(active_period == 0, "R1 period", active_period, 0);
    endtask

    task automatic t_up();
        do_reset();
        wr(0, 16'h000B); wr(1, 16'd4); wr(0, 16'h0008);
        for (int i = 0; i < 12; i++) begin
            int e = i % 5;
            chk(count == e, "R2 up count", count, e);
            chk(zero_evt == (e == 0), "R7 up zero_evt", zero_evt, int'(e == 0));
            chk(period_evt == (e == 4), "R7 up period_evt", period_evt, int'(e == 4));
            chk(dir_up == 1, "R2 dir_up", dir_up, 1);
            step();
        end
    endtask

    task automatic t_down();
        do_reset();
        wr(0, 16'h000B); wr(1, 16'd4); wr(0, 16'h0009);
        for (int i = 0; i < 12; i++) begin
            int e = (i == 0) ? 0 : 4 - ((i - 1) % 5);
            chk(count == e, "R3 down count", count, e);
            chk(zero_evt == (e == 0), "R3 zero_evt", zero_evt, int'(e == 0));
            chk(period_evt == (e == 4), "R3 period_evt", period_evt, int'(e == 4));
            chk(dir_up == 0, "R3 dir_up", dir_up, 0);
            step();
        end
    endtask

    task automatic t_updn();
        do_reset();
        wr(0, 16'h000B); wr(1, 16'd3); wr(0, 16'h000A);
        for (int i = 0; i < 14; i++) begin
            int p = i % 6;
            int e = (p <= 3) ? p : 6 - p;
            bit d = (p <= 3) && !(p == 0 && i > 0);
            chk(count == e, "R4 updn count", count, e);
            chk(dir_up == d, "R4 updn dir_up", dir_up, int'(d));
            step();
        end
    endtask

    task automatic t_hold();
        int c0;
        do_reset();
        wr(0, 16'h000B); wr(1, 16'd4); wr(0, 16'h0008);
        step(); step();
        wr(0, 16'h000B);
        c0 = count;
        chk(c0 == 3, "R5 hold entry count", c0, 3);
        for (int i = 0; i < 6; i++) begin
            chk(count == c0, "R5 hold count", count, c0);
            chk(!zero_evt && !period_evt, "R5 hold strobes", int'(zero_evt | period_evt), 0);
            step();
        end
    endtask

    task automatic t_div(input int n, input int m);
        int expd = (1 << n) * ((m == 0) ? 1 : 2 * m);
        logic [15:0] base = 16'((n << 10) | (m << 7) | 8);
        int gap = 0;
        logic [15:0] last;
        do_reset();
        wr(0, base | 16'h0003); wr(1, 16'd1000); wr(0, base);
        for (int k = 0; k < 3; k++) begin
            last = count;
            gap = 0;
            while (count == last && gap < 400) begin
                step();
                gap++;
            end
        end
        chk(gap == expd, "R6 tick spacing", gap, expd);
    endtask

    task automatic t_width();
        int zc = 0;
        int pc = 0;
        int run = 0;
        int maxrun = 0;
        do_reset();
        wr(0, 16'h050B); wr(1, 16'd2); wr(0, 16'h0508);
        for (int i = 0; i < 48; i++) begin
            if (zero_evt) zc++;
            if (period_evt) pc++;
            run = zero_evt ? run + 1 : 0;
            if (run > maxrun) maxrun = run;
            step();
        end
        chk(zc == 2, "R7 zero_evt count", zc, 2);
        chk(pc == 2, "R7 period_evt count", pc, 2);
        chk(maxrun == 1, "R7 strobe width", maxrun, 1);
    endtask

    task automatic t_shadow();
        do_reset();
        wr(0, 16'h000B); wr(1, 16'd5); wr(0, 16'h0000);
        chk(count == 0, "R8 start", count, 0);
        step(); step();
        wr(1, 16'd2);
        chk(count == 3 && active_period == 5, "R8 held after write", active_period, 5);
        step(); step();
        chk(count == 5 && period_evt, "R8 old period used", count, 5);
        step();
        chk(count == 0 && active_period == 5, "R8 held at zero", active_period, 5);
        step();
        chk(count == 1 && active_period == 2, "R8 loaded after zero", active_period, 2);
        step();
        chk(count == 2 && period_evt == 1, "R8 new period end", count, 2);
        step();
        chk(count == 0, "R8 wrap at new period", count, 0);
    endtask

    task automatic t_imm();
        do_reset();
        wr(0, 16'h000B); wr(1, 16'd5); wr(0, 16'h0008);
        step(); step(); step();
        wr(1, 16'd2);
        chk(active_period == 2, "R9 immediate period", active_period, 2);
        chk(count == 4, "R10 write edge count", count, 4);
        step();
        chk(count == 0, "R9 wrap on new period", count, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_up();
        t_down();
        t_updn();
        t_hold();
        t_div(0, 0);
        t_div(1, 2);
        t_div(2, 0);
        t_div(0, 3);
        t_div(3, 1);
        t_width();
        t_shadow();
        t_imm();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule